// File: doc/BRIEF.md
# Parallel Flash Bus Cycle Engine

This block sequences the pins of an asynchronous parallel memory bus built from flash devices: a 21-bit address, a 32-bit data path split into separate drive and sense vectors with a drive-enable, and active-low select, output-enable and write-enable strobes. A host side hands it one request at a time: a single write, a single read, or a read burst over consecutive addresses. The engine produces the strobe waveform with clock-counted phases and returns each sampled word with a one-cycle valid strobe.

Phase lengths are elaboration parameters counted in system clocks. The write setup length, the write-strobe width, the hold after a strobe and the read access delay are each one parameter. A value below one is treated as one. The read access delay must cover the device access time, which is roughly 70 to 140 ns for the parts in view. Flash command sequencing such as unlock, program and erase sits above this block and is built from its single write and read requests.

Top module: `pfbus_engine`

## Requirements
- R1: While reset is held and in the first cycle after it, select, output enable and write enable are high, drive-enable is low, the address is zero, busy is low and the read valid strobe is low.
- R2: A write request (op code 2'b01) gives SETUP_CLKS cycles with select low, output enable high, write enable high, the address and data driven and drive-enable high. Then come PULSE_CLKS cycles that differ only in write enable being low, then HOLD_CLKS cycles with write enable high again and select, address and data still held.
- R3: A single read (op code 2'b10) first spends one cycle with select low, output enable high and drive-enable low. It then holds output enable low for ACCESS_CLKS cycles. The data input is sampled at the clock edge that ends the last of those cycles, and rd_valid is high for exactly the next cycle with that word. Output enable then returns high for HOLD_CLKS cycles with select still low.
- R4: A burst read (op code 2'b11) of length N gives N beats of ACCESS_CLKS cycles each, with select and output enable held low across all beats and the address rising by one per beat. Each word follows R3's sample and valid timing. A length of zero gives one beat.
- R5: The burst address wraps from the top of the 21-bit range to zero.
- R6: Op code 2'b00 with req_valid high starts nothing: busy and all bus pins stay in the idle state.
- R7: A request offered while busy is high is dropped, and the operation in progress continues unchanged.
- R8: busy rises in the cycle after an accepted request and falls in the cycle after the last hold cycle. While busy is low all strobes are high, drive-enable is low and the address keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered this cycle |
| req_op | input | 2 | 01 write, 10 read, 11 burst read, 00 none |
| req_addr | input | 21 | Start address |
| req_wdata | input | 32 | Write data |
| req_len | input | 8 | Burst beat count, 0 meaning 1 |
| busy | output | 1 | An operation is in progress |
| rd_valid | output | 1 | rd_data holds a new sampled word |
| rd_data | output | 32 | Last sampled read word |
| mem_addr | output | 21 | Memory address bus |
| mem_dq_out | output | 32 | Data driven toward memory |
| mem_dq_oe | output | 1 | Drive-enable for mem_dq_out |
| mem_dq_in | input | 32 | Data sensed from memory |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |

## Verification
A phase counter that is off by one stretches or cuts a strobe. That shows on the pins within a single phase, because the write strobe or output enable changes level one cycle early or late. A wrong beat count or address step shows as an extra or missing valid strobe, or as a word fetched from the wrong address, in the beat where it happens. A state that leaves drive-enable high into a read turns up in the turnaround cycle, before output enable falls. The bench holds the expected level of every pin for every cycle and compares each clock, so a fault is reported in the first cycle it reaches a port.

// File: rtl/pfbus_pkg.sv
package pfbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSETUP,
        ST_WPULSE,
        ST_WHOLD,
        ST_RTURN,
        ST_RACCESS,
        ST_REND
    } pf_state_e;

    localparam logic [1:0] OP_NONE  = 2'b00;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_BURST = 2'b11;

endpackage

// File: rtl/pfbus_phase_timer.sv
module pfbus_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q > CNT_W'(1)) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // remaining cycles of the phase, counting the present one
    assign expire = (cnt_q <= CNT_W'(1));

    a_r2_count_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load) |-> (cnt_q <= $past(cnt_q)));

endmodule

// File: rtl/pfbus_capture.sv
module pfbus_capture #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [DATA_W-1:0] din,
    output logic              valid,
    output logic [DATA_W-1:0] data
);

    logic              valid_d, valid_q;
    logic [DATA_W-1:0] data_d, data_q;

    always_comb begin
        valid_d = take;
        data_d  = take ? din : data_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            data_q  <= '0;
        end else begin
            valid_q <= valid_d;
            data_q  <= data_d;
        end
    end

    assign valid = valid_q;
    assign data  = data_q;

    a_r3_data_held_between_words: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_q |-> $stable(data_q));

endmodule

// File: rtl/pfbus_engine.sv
module pfbus_engine
    import pfbus_pkg::*;
#(
    parameter int ADDR_W      = 21,
    parameter int DATA_W      = 32,
    parameter int LEN_W       = 8,
    parameter int SETUP_CLKS  = 1,
    parameter int PULSE_CLKS  = 4,
    parameter int HOLD_CLKS   = 1,
    parameter int ACCESS_CLKS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LEN_W-1:0]  req_len,
    output logic              busy,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n
);

    localparam int SETUP_N  = (SETUP_CLKS  < 1) ? 1 : SETUP_CLKS;
    localparam int PULSE_N  = (PULSE_CLKS  < 1) ? 1 : PULSE_CLKS;
    localparam int HOLD_N   = (HOLD_CLKS   < 1) ? 1 : HOLD_CLKS;
    localparam int ACCESS_N = (ACCESS_CLKS < 1) ? 1 : ACCESS_CLKS;
    localparam int MAX_AB   = (SETUP_N > PULSE_N) ? SETUP_N : PULSE_N;
    localparam int MAX_CD   = (HOLD_N > ACCESS_N) ? HOLD_N : ACCESS_N;
    localparam int MAX_N    = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CNT_W    = $clog2(MAX_N + 1);

    localparam logic [CNT_W-1:0] LD_SETUP  = CNT_W'(SETUP_N);
    localparam logic [CNT_W-1:0] LD_PULSE  = CNT_W'(PULSE_N);
    localparam logic [CNT_W-1:0] LD_HOLD   = CNT_W'(HOLD_N);
    localparam logic [CNT_W-1:0] LD_ACCESS = CNT_W'(ACCESS_N);
    localparam logic [CNT_W-1:0] LD_TURN   = CNT_W'(1);

    typedef struct packed {
        pf_state_e         st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [LEN_W-1:0]  beats;
        logic              ce_n;
        logic              oe_n;
        logic              we_n;
        logic              dq_oe;
    } eng_regs_t;

    eng_regs_t        r_d, r_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expire;
    logic             cap_take;

    pfbus_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (tmr_expire)
    );

    pfbus_capture #(.DATA_W(DATA_W)) u_capture (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (cap_take),
        .din   (mem_dq_in),
        .valid (rd_valid),
        .data  (rd_data)
    );

    always_comb begin
        r_d      = r_q;
        tmr_load = 1'b0;
        tmr_val  = LD_TURN;
        cap_take = 1'b0;

        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    unique case (req_op)
                        OP_WRITE: begin
                            r_d.st    = ST_WSETUP;
                            r_d.addr  = req_addr;
                            r_d.wdata = req_wdata;
                            tmr_load  = 1'b1;
                            tmr_val   = LD_SETUP;
                        end
                        OP_READ, OP_BURST: begin
                            r_d.st    = ST_RTURN;
                            r_d.addr  = req_addr;
                            r_d.beats = (req_op == OP_READ || req_len == '0)
                                        ? LEN_W'(1) : req_len;
                            tmr_load  = 1'b1;
                            tmr_val   = LD_TURN;
                        end
                        default: ;
                    endcase
                end
            end
            ST_WSETUP: begin
                if (tmr_expire) begin
                    r_d.st   = ST_WPULSE;
                    tmr_load = 1'b1;
                    tmr_val  = LD_PULSE;
                end
            end
            ST_WPULSE: begin
                if (tmr_expire) begin
                    r_d.st   = ST_WHOLD;
                    tmr_load = 1'b1;
                    tmr_val  = LD_HOLD;
                end
            end
            ST_WHOLD: begin
                if (tmr_expire) begin
                    r_d.st = ST_IDLE;
                end
            end
            ST_RTURN: begin
                if (tmr_expire) begin
                    r_d.st   = ST_RACCESS;
                    tmr_load = 1'b1;
                    tmr_val  = LD_ACCESS;
                end
            end
            ST_RACCESS: begin
                if (tmr_expire) begin
                    cap_take = 1'b1;
                    tmr_load = 1'b1;
                    if (r_q.beats <= LEN_W'(1)) begin
                        r_d.st  = ST_REND;
                        tmr_val = LD_HOLD;
                    end else begin
                        r_d.beats = r_q.beats - LEN_W'(1);
                        r_d.addr  = r_q.addr + ADDR_W'(1);
                        tmr_val   = LD_ACCESS;
                    end
                end
            end
            ST_REND: begin
                if (tmr_expire) begin
                    r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        // strobes are registered from the state being entered
        r_d.ce_n  = (r_d.st == ST_IDLE);
        r_d.oe_n  = (r_d.st != ST_RACCESS);
        r_d.we_n  = (r_d.st != ST_WPULSE);
        r_d.dq_oe = (r_d.st == ST_WSETUP) || (r_d.st == ST_WPULSE) ||
                    (r_d.st == ST_WHOLD);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st    <= ST_IDLE;
            r_q.addr  <= '0;
            r_q.wdata <= '0;
            r_q.beats <= '0;
            r_q.ce_n  <= 1'b1;
            r_q.oe_n  <= 1'b1;
            r_q.we_n  <= 1'b1;
            r_q.dq_oe <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy       = (r_q.st != ST_IDLE);
    assign mem_addr   = r_q.addr;
    assign mem_dq_out = r_q.wdata;
    assign mem_dq_oe  = r_q.dq_oe;
    assign mem_ce_n   = r_q.ce_n;
    assign mem_oe_n   = r_q.oe_n;
    assign mem_we_n   = r_q.we_n;

    a_r8_idle_releases_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe));

    a_r2_strobe_inside_write: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe &&
                       $stable(mem_addr) && $stable(mem_dq_out)));

    a_r3_turnaround_before_read: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_dq_oe && !$past(mem_dq_oe)));

    a_r4_burst_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n && !$past(mem_oe_n) && (mem_addr != $past(mem_addr)))
            |-> (mem_addr == ADDR_W'($past(mem_addr) + ADDR_W'(1))));

    a_r3_valid_follows_access: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !$past(mem_oe_n));

    a_r8_select_tracks_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !mem_ce_n);

endmodule

// File: tb/pfbus_engine_bench.sv
`timescale 1ns/1ps
module pfbus_engine_bench;

    localparam int S = 1;
    localparam int P = 4;
    localparam int H = 1;
    localparam int A = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b00;
    logic [20:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [7:0]  req_len = '0;
    logic        busy, rd_valid, mem_dq_oe, mem_ce_n, mem_oe_n, mem_we_n;
    logic [31:0] rd_data, mem_dq_out, mem_dq_in;
    logic [20:0] mem_addr;

    always #2 clk = ~clk;

    pfbus_engine u_pfbus_engine (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_len(req_len),
        .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n)
    );

    function automatic logic [31:0] pat(input logic [20:0] a);
        return {a[10:0], a} ^ 32'h5A3C_96E1;
    endfunction

    // memory model: true word only while selected and output-enabled
    assign mem_dq_in = (!mem_ce_n && !mem_oe_n) ? pat(mem_addr) : ~pat(mem_addr);

    typedef struct packed {
        logic        ce_n, oe_n, we_n, dq_oe, busy, rv;
        logic [20:0] addr;
        logic [31:0] dq;
        logic [31:0] rd;
        logic [3:0]  tg;
    } exp_t;

    exp_t        q[$];
    logic [20:0] last_addr = '0;
    bit          cur_busy = 1'b0;
    bit          done = 1'b0;
    int          total = 0;
    int          fails = 0;

    function automatic string tname(input logic [3:0] t);
        case (t)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            default: return "R8";
        endcase
    endfunction

    function automatic exp_t mk(input logic ce, oe, we, oeq, bz,
                                input logic [20:0] a, input logic [31:0] d,
                                input logic [3:0] t);
        exp_t e;
        e.ce_n = ce; e.oe_n = oe; e.we_n = we; e.dq_oe = oeq; e.busy = bz;
        e.rv = 1'b0; e.addr = a; e.dq = d; e.rd = '0; e.tg = t;
        return e;
    endfunction

    task automatic chk(input bit ok, input logic [3:0] t, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=%0h exp=%0h at %0t", tname(t), what, act, exp, $time);
        end
    endtask

    task automatic step();
        exp_t e;
        @(negedge clk);
        if (q.size() != 0) e = q.pop_front();
        else e = mk(1, 1, 1, 0, 0, last_addr, '0, 4'd8);
        cur_busy = e.busy;
        chk(mem_ce_n == e.ce_n, e.tg, "ce_n", 64'(mem_ce_n), 64'(e.ce_n));
        chk(mem_oe_n == e.oe_n, e.tg, "oe_n", 64'(mem_oe_n), 64'(e.oe_n));
        chk(mem_we_n == e.we_n, e.tg, "we_n", 64'(mem_we_n), 64'(e.we_n));
        chk(mem_dq_oe == e.dq_oe, e.tg, "dq_oe", 64'(mem_dq_oe), 64'(e.dq_oe));
        chk(busy == e.busy, e.tg, "busy", 64'(busy), 64'(e.busy));
        chk(mem_addr == e.addr, e.tg, "addr", 64'(mem_addr), 64'(e.addr));
        chk(rd_valid == e.rv, e.tg, "rd_valid", 64'(rd_valid), 64'(e.rv));
        if (e.dq_oe) chk(mem_dq_out == e.dq, e.tg, "dq_out", 64'(mem_dq_out), 64'(e.dq));
        if (e.rv) chk(rd_data == e.rd, e.tg, "rd_data", 64'(rd_data), 64'(e.rd));
    endtask

    task automatic model_write(input logic [20:0] a, input logic [31:0] d, input logic [3:0] t);
        for (int i = 0; i < S; i++) q.push_back(mk(0, 1, 1, 1, 1, a, d, t));
        for (int i = 0; i < P; i++) q.push_back(mk(0, 1, 0, 1, 1, a, d, t));
        for (int i = 0; i < H; i++) q.push_back(mk(0, 1, 1, 1, 1, a, d, t));
        last_addr = a;
    endtask

    task automatic model_read(input logic [20:0] a, input int n_in, input logic [3:0] t);
        int n = (n_in == 0) ? 1 : n_in;
        bit pend = 1'b0;
        logic [31:0] pdat = '0;
        logic [20:0] ba = a;
        exp_t e;
        q.push_back(mk(0, 1, 1, 0, 1, a, '0, t));
        for (int b = 0; b < n; b++) begin
            ba = a + 21'(b);
            for (int j = 0; j < A; j++) begin
                e = mk(0, 0, 1, 0, 1, ba, '0, t);
                if (pend) begin e.rv = 1'b1; e.rd = pdat; pend = 1'b0; end
                q.push_back(e);
            end
            pend = 1'b1;
            pdat = pat(ba);
        end
        for (int i = 0; i < H; i++) begin
            e = mk(0, 1, 1, 0, 1, ba, '0, t);
            if (pend) begin e.rv = 1'b1; e.rd = pdat; pend = 1'b0; end
            q.push_back(e);
        end
        last_addr = ba;
    endtask

    // drive a request for one cycle; the model accepts it only when idle
    task automatic issue(input logic [1:0] op, input logic [20:0] a,
                         input logic [31:0] d, input logic [7:0] len,
                         input logic [3:0] t);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d; req_len = len;
        if (!cur_busy) begin
            case (op)
                2'b01: model_write(a, d, t);
                2'b10: model_read(a, 1, t);
                2'b11: model_read(a, int'(len), t);
                default: ;
            endcase
        end
        step();
        req_valid = 1'b0; req_op = 2'b00;
    endtask

    task automatic wait_idle();
        while (q.size() != 0 || cur_busy) step();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state while reset is held
        chk(mem_ce_n && mem_oe_n && mem_we_n, 4'd1, "strobes in reset",
            64'({mem_ce_n, mem_oe_n, mem_we_n}), 64'h7);
        chk(!mem_dq_oe && !busy && !rd_valid, 4'd1, "dq_oe/busy/rv in reset",
            64'({mem_dq_oe, busy, rd_valid}), 64'h0);
        chk(mem_addr == '0, 4'd1, "addr in reset", 64'(mem_addr), 64'h0);
        rst_n = 1'b1;
        step();
        step();

        // R2: writes, including the top address
        issue(2'b01, 21'h00123, 32'hDEAD_BEEF, 8'd0, 4'd2);
        wait_idle();
        issue(2'b01, 21'h1FFFFF, 32'h0F0F_A5A5, 8'd0, 4'd2);
        wait_idle();

        // R3: single read, R4: burst and zero length
        issue(2'b10, 21'h00040, '0, 8'd9, 4'd3);
        wait_idle();
        issue(2'b11, 21'h00100, '0, 8'd4, 4'd4);
        wait_idle();
        issue(2'b11, 21'h00200, '0, 8'd0, 4'd4);
        wait_idle();

        // R5: burst across the top of the address range
        issue(2'b11, 21'h1FFFFE, '0, 8'd4, 4'd5);
        wait_idle();

        // R6: op none while idle leaves the bus idle
        issue(2'b00, 21'h0ABCD, 32'h1234_5678, 8'd3, 4'd6);
        for (int i = 0; i < 3; i++) q.push_back(mk(1, 1, 1, 0, 0, last_addr, '0, 4'd6));
        wait_idle();

        // R7: requests while busy are dropped
        issue(2'b11, 21'h00300, '0, 8'd3, 4'd7);
        repeat (5) step();
        issue(2'b01, 21'h00777, 32'hCAFE_F00D, 8'd0, 4'd7);
        repeat (4) step();
        issue(2'b10, 21'h00555, '0, 8'd0, 4'd7);
        wait_idle();

        // R8: back-to-back operations right after busy falls
        issue(2'b01, 21'h00010, 32'h1111_2222, 8'd0, 4'd8);
        wait_idle();
        issue(2'b10, 21'h00010, '0, 8'd0, 4'd8);
        wait_idle();
        repeat (2) step();

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL R8 watchdog act=running exp=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule